// File: doc/BRIEF.md
# Pointer Tag Generator with Exclusion-Skipping Walk

This block produces a 4-bit allocation tag for a 64-bit pointer and writes it into bits 59:56 of that pointer. A random request takes its step count from a 16-bit right-shifting pseudo-random seed, advanced four times per request. It then walks upward from the previously issued tag and skips every value set in an exclusion mask. The new seed and the chosen tag are written back together into a 24-bit state register, so the next random request continues from there.

An adjust request instead starts the walk from the tag already held in the pointer and uses a caller-supplied step count. It returns the pointer moved by a signed byte offset and carrying the new tag. It leaves the state register alone.

The walk is sequential, one candidate tag per clock. A request is accepted only while `busy` is low. The result and any state update appear in the same cycle as a single-cycle `done` pulse.

Top module: `ptag_gen`

## Requirements
- R1: After reset (synchronous, active low), `state_out` and `ptr_out` are zero and `busy` and `done` are low.
- R2: A request is taken when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the result appears. `done` is high for exactly one cycle. Requests raised while `busy` is high are ignored and change neither the result nor the number of `done` pulses.
- R3: One seed step forms the bit b = s[5]^s[3]^s[2]^s[0], then shifts the seed right by one with b entering bit 15. A random request performs four steps. The bit from step i (i = 0..3) becomes bit i of the step count.
- R4: On a random request with `rand_mode` high and a seed of zero, the seed is first replaced by 16'h0001.
- R5: The exclusion mask of a random request is `excl_op | excl_glb`. Bit k set means tag value k may not be chosen.
- R6: When the exclusion mask is all ones, the tag is 0 whatever the start tag and step count.
- R7: With a step count of zero, the tag is the first non-excluded value counting upward from the start tag modulo 16, the start tag included.
- R8: With a step count N > 0, the walk moves upward N times modulo 16. Each move lands on the next non-excluded value, so the start tag is never the result of the first move.
- R9: On a random request the state register is rewritten with the chosen tag in bits 3:0, the advanced seed in bits 23:8 and zero in bits 7:4. The start tag of a random request is state bits 3:0, and its seed is state bits 23:8. The state holds in every other cycle.
- R10: An adjust request (`req_adj` = 1) starts from `ptr_in[59:56]`, steps `tag_ofs` times, excludes by `excl_glb` alone (ignoring `excl_op`), and returns `ptr_in` plus the sign-extended `byte_ofs`. It leaves `state_out` unchanged.
- R11: `ptr_out` equals the request's base pointer with bits 59:56 replaced by the chosen tag. For a random request the base pointer is `ptr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_adj | input | 1 | 0 = random request, 1 = adjust request |
| ptr_in | input | 64 | Source pointer |
| excl_op | input | 16 | Per-request exclusion mask (random requests only) |
| excl_glb | input | 16 | Global exclusion mask |
| rand_mode | input | 1 | Allows replacing a zero seed before stepping |
| byte_ofs | input | 16 | Signed byte offset for adjust requests |
| tag_ofs | input | 4 | Step count for adjust requests |
| busy | output | 1 | Walk in progress; new requests ignored |
| done | output | 1 | One-cycle pulse marking a valid result |
| ptr_out | output | 64 | Pointer carrying the chosen tag |
| state_out | output | 24 | Seed (23:8) and last tag (3:0) |

## Verification
Starting from the reset state, where the seed is zero, a random request gives a zero step count. This isolates the start-inclusive rule of R7, and the split of exclusion bits between the two masks confirms the OR of R5. Replacing the zero seed yields a literal known state value, which fixes the tap positions and the bit order of the step count. A chain of random requests with varied masks is compared against a bench model of the seed and the walk, so errors in state write-back show up on later requests. Adjust requests cover several corners: a wrap past 15, a mask leaving only the start tag free (the walk must go all the way round), a fully masked per-request operand that must be ignored, and a request raised repeatedly during a long walk that must leave no trace.

// File: rtl/ptag_pkg.sv
// Shared constants and types for the pointer tag generator.
// Assumes a tag of four bits and a sixteen-bit seed; widths derive from these.
package ptag_pkg;
    localparam int TAG_W    = 4;
    localparam int NTAG     = 1 << TAG_W;
    localparam int SEED_W   = 16;
    localparam int SEED_OFF = 8;
    localparam int STATE_W  = SEED_OFF + SEED_W;

    typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/ptag_lfsr.sv
// Combinational multi-step seed advance.
// Each step forms b = s[5]^s[3]^s[2]^s[0], shifts right and inserts b at the top.
// Step g contributes bit g of bits_o. Assumes SEED_W >= 6.
module ptag_lfsr #(
    parameter int SEED_W = 16,
    parameter int STEPS  = 4
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic [STEPS-1:0]  bits_o,
    output logic [SEED_W-1:0] seed_o
);
    logic [SEED_W-1:0] chain [STEPS+1];

    assign chain[0] = seed_i;

    // One shift stage per step; stage g feeds stage g+1.
    for (genvar g = 0; g < STEPS; g++) begin : g_step
        logic fb;
        assign fb         = chain[g][5] ^ chain[g][3] ^ chain[g][2] ^ chain[g][0];
        assign chain[g+1] = {fb, chain[g][SEED_W-1:1]};
        assign bits_o[g]  = fb;
    end

    assign seed_o = chain[STEPS];
endmodule

// File: rtl/ptag_walker.sv
// Sequential exclusion-skipping tag walk, one candidate per cycle.
// With zero moves it settles on the first free value from start (inclusive);
// otherwise it advances until it has landed on a free value N times.
// An all-ones mask finishes at once with tag 0. The caller raises go only while idle.
module ptag_walker #(
    parameter int TAG_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic [TAG_W-1:0]        start_tag,
    input  logic [TAG_W-1:0]        moves,
    input  logic [(1<<TAG_W)-1:0]   excl,
    output logic                    busy,
    output logic                    fin,
    output logic [TAG_W-1:0]        fin_tag
);
    localparam int NTAG  = 1 << TAG_W;
    localparam int CNT_W = 2 * TAG_W + 1;

    logic             active;
    logic             zmode;
    logic             allx;
    logic [TAG_W-1:0] cur;
    logic [TAG_W-1:0] left;
    logic [NTAG-1:0]  mask;
    logic [TAG_W-1:0] nxt;
    logic             cur_ok;
    logic             nxt_ok;

    // Candidate evaluation for the current cycle.
    always_comb begin
        nxt     = cur + TAG_W'(1);
        cur_ok  = !mask[cur];
        nxt_ok  = !mask[nxt];
        fin     = active && (allx || (zmode ? cur_ok : (nxt_ok && left == TAG_W'(1))));
        fin_tag = allx ? '0 : (zmode ? cur : nxt);
    end

    assign busy = active;

    // Walk state: load on go, step until finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            zmode  <= 1'b0;
            allx   <= 1'b0;
            cur    <= '0;
            left   <= '0;
            mask   <= '0;
        end else if (go && !active) begin
            active <= 1'b1;
            zmode  <= (moves == '0);
            allx   <= &excl;
            cur    <= start_tag;
            left   <= moves;
            mask   <= excl;
        end else if (active) begin
            if (fin) begin
                active <= 1'b0;
            end else begin
                cur <= nxt;
                if (!zmode && nxt_ok) left <= left - TAG_W'(1);
            end
        end
    end

    // Cycle count of the current walk, used only to bound it.
    logic [CNT_W-1:0] walk_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !active) walk_cnt <= '0;
        else                   walk_cnt <= walk_cnt + CNT_W'(1);
    end

    assert_walk_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (walk_cnt <= CNT_W'(NTAG * NTAG)));

    assert_result_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !allx) |-> !mask[fin_tag]);

    assert_fullmask_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && allx) |-> (fin && fin_tag == '0));
endmodule

// File: rtl/ptag_gen.sv
// Pointer tag generator top. Selects start tag, step count and mask per request
// kind, launches the walk, then writes the tagged pointer and (random kind only)
// the seed/tag state on the finishing edge, raising done for one cycle.
// Assumes TAG_W < SEED_OFF so the state fields do not overlap.
module ptag_gen
    import ptag_pkg::*;
#(
    parameter int               PTR_W      = 64,
    parameter int               OFS_W      = 16,
    parameter int               TAG_LSB    = 56,
    parameter logic [SEED_W-1:0] FIXED_SEED = 16'h0001
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_adj,
    input  logic [PTR_W-1:0]     ptr_in,
    input  logic [NTAG-1:0]      excl_op,
    input  logic [NTAG-1:0]      excl_glb,
    input  logic                 rand_mode,
    input  logic [OFS_W-1:0]     byte_ofs,
    input  logic [TAG_W-1:0]     tag_ofs,
    output logic                 busy,
    output logic                 done,
    output logic [PTR_W-1:0]     ptr_out,
    output logic [STATE_W-1:0]   state_out
);
    logic [STATE_W-1:0] state_q;
    logic [SEED_W-1:0]  seed_cur;
    logic [SEED_W-1:0]  seed_use;
    logic [SEED_W-1:0]  seed_adv;
    logic [TAG_W-1:0]   rnd_steps;
    logic               go;
    logic [TAG_W-1:0]   start_sel;
    logic [TAG_W-1:0]   moves_sel;
    logic [NTAG-1:0]    excl_sel;
    logic [PTR_W-1:0]   base_sel;
    logic               walk_fin;
    tag_t               walk_tag;

    logic               adj_q;
    logic               mode_q;
    logic [SEED_W-1:0]  seed_q;
    logic [PTR_W-1:0]   base_q;
    logic [PTR_W-1:0]   ptr_new;
    logic               done_q;
    logic [PTR_W-1:0]   ptr_q;

    // Seed to step from, substituting the fixed value for a zero seed in mode.
    always_comb begin
        seed_cur = state_q[SEED_OFF +: SEED_W];
        seed_use = (rand_mode && seed_cur == '0) ? FIXED_SEED : seed_cur;
    end

    ptag_lfsr #(.SEED_W(SEED_W), .STEPS(TAG_W)) u_lfsr (
        .seed_i (seed_use),
        .bits_o (rnd_steps),
        .seed_o (seed_adv)
    );

    // Per-kind selection of walk inputs and base pointer.
    always_comb begin
        go        = req_valid && !busy;
        start_sel = req_adj ? ptr_in[TAG_LSB +: TAG_W] : state_q[TAG_W-1:0];
        moves_sel = req_adj ? tag_ofs : rnd_steps;
        excl_sel  = req_adj ? excl_glb : (excl_op | excl_glb);
        base_sel  = req_adj ? (ptr_in + {{(PTR_W-OFS_W){byte_ofs[OFS_W-1]}}, byte_ofs})
                            : ptr_in;
    end

    ptag_walker #(.TAG_W(TAG_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .start_tag (start_sel),
        .moves     (moves_sel),
        .excl      (excl_sel),
        .busy      (busy),
        .fin       (walk_fin),
        .fin_tag   (walk_tag)
    );

    // Request context captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_q  <= 1'b0;
            mode_q <= 1'b0;
            seed_q <= '0;
            base_q <= '0;
        end else if (go) begin
            adj_q  <= req_adj;
            mode_q <= rand_mode;
            seed_q <= seed_adv;
            base_q <= base_sel;
        end
    end

    // Base pointer with the chosen tag spliced in.
    always_comb begin
        ptr_new = base_q;
        ptr_new[TAG_LSB +: TAG_W] = walk_tag;
    end

    // Result, done pulse and state write-back on the finishing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            ptr_q   <= '0;
            state_q <= '0;
        end else begin
            done_q <= walk_fin;
            if (walk_fin) begin
                ptr_q <= ptr_new;
                if (!adj_q) begin
                    state_q[SEED_OFF +: SEED_W]     <= seed_q;
                    state_q[SEED_OFF-1:TAG_W]       <= '0;
                    state_q[TAG_W-1:0]              <= walk_tag;
                end
            end
        end
    end

    assign done      = done_q;
    assign ptr_out   = ptr_q;
    assign state_out = state_q;

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_adjust_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && adj_q) |-> $stable(state_out));

    assert_state_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(state_out));

    assert_seed_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !adj_q && mode_q) |-> (state_out[SEED_OFF +: SEED_W] != '0));
endmodule

// File: tb/tb_ptag_gen.sv
module tb_ptag_gen;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_adj = 1'b0;
    logic [63:0] ptr_in = '0;
    logic [15:0] excl_op = '0;
    logic [15:0] excl_glb = '0;
    logic        rand_mode = 1'b0;
    logic [15:0] byte_ofs = '0;
    logic [3:0]  tag_ofs = '0;
    logic        busy;
    logic        done;
    logic [63:0] ptr_out;
    logic [23:0] state_out;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    logic [23:0] m_state = '0;

    always #(CLK_P/2) clk = ~clk;

    ptag_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_adj(req_adj),
        .ptr_in(ptr_in), .excl_op(excl_op), .excl_glb(excl_glb),
        .rand_mode(rand_mode), .byte_ofs(byte_ofs), .tag_ofs(tag_ofs),
        .busy(busy), .done(done), .ptr_out(ptr_out), .state_out(state_out)
    );

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired got %0d cycles expected fewer", cycles);
            report();
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] m_pick(input logic [3:0] st, input logic [3:0] n,
                                          input logic [15:0] ex);
        logic [3:0] t;
        if (ex == 16'hFFFF) return 4'd0;
        t = st;
        if (n == 0) begin
            while (ex[t]) t = t + 4'd1;
        end else begin
            for (int k = 0; k < int'(n); k++) begin
                t = t + 4'd1;
                while (ex[t]) t = t + 4'd1;
            end
        end
        return t;
    endfunction

    function automatic logic [19:0] m_steps(input logic [15:0] s);
        logic [15:0] v;
        logic [3:0]  o;
        logic        b;
        v = s;
        for (int i = 0; i < 4; i++) begin
            b = v[5] ^ v[3] ^ v[2] ^ v[0];
            o[i] = b;
            v = {b, v[15:1]};
        end
        return {v, o};
    endfunction

    function automatic logic [63:0] with_tag(input logic [63:0] p, input logic [3:0] t);
        logic [63:0] r;
        r = p;
        r[59:56] = t;
        return r;
    endfunction

    // Launch one request and wait for its done pulse (sampled on falling edges).
    task automatic run_req(input logic adj, input logic [63:0] p, input logic [15:0] eo,
                           input logic [15:0] eg, input logic md, input logic [15:0] bo,
                           input logic [3:0] to);
        int w;
        @(negedge clk);
        req_adj = adj; ptr_in = p; excl_op = eo; excl_glb = eg;
        rand_mode = md; byte_ofs = bo; tag_ofs = to; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!done && w < 1000) begin
            @(negedge clk);
            w++;
        end
    endtask

    // Random request against the bench model; updates the model state.
    task automatic rand_req(input string tag, input logic [63:0] p, input logic [15:0] eo,
                            input logic [15:0] eg, input logic md);
        logic [15:0] s;
        logic [19:0] r;
        logic [3:0]  t;
        s = m_state[23:8];
        if (md && s == 0) s = 16'h0001;
        r = m_steps(s);
        t = m_pick(m_state[3:0], r[3:0], eo | eg);
        run_req(1'b0, p, eo, eg, md, 16'h0, 4'h0);
        check({tag, " done"}, {63'b0, done}, 64'd1);
        check({tag, " ptr"}, ptr_out, with_tag(p, t));
        m_state = {r[19:4], 4'h0, t};
        check({tag, " state"}, {40'b0, state_out}, {40'b0, m_state});
    endtask

    task automatic t_reset;
        check("R1 state", {40'b0, state_out}, 64'd0);
        check("R1 ptr", ptr_out, 64'd0);
        check("R1 busy/done", {62'b0, busy, done}, 64'd0);
    endtask

    task automatic t_zero_seed;
        // seed 0, mode off: zero steps, start 0, 0..2 masked across both masks.
        run_req(1'b0, 64'h0123_4567_89AB_CDEF, 16'h0003, 16'h0004, 1'b0, 16'h0, 4'h0);
        check("R7 R5 R11 ptr", ptr_out, 64'h0323_4567_89AB_CDEF);
        check("R9 state", {40'b0, state_out}, 64'h3);
        m_state = 24'h000003;
        @(negedge clk);
        check("R2 done falls", {63'b0, done}, 64'd0);
    endtask

    task automatic t_mode_seed;
        // seed forced to 1 -> steps 1, seed 0x1000; start 3 -> tag 4.
        run_req(1'b0, 64'hF0F0_0000_0000_0010, 16'h0, 16'h0, 1'b1, 16'h0, 4'h0);
        check("R4 R3 state", {40'b0, state_out}, 64'h100004);
        check("R4 ptr", ptr_out, 64'hF4F0_0000_0000_0010);
        m_state = 24'h100004;
    endtask

    task automatic t_chain;
        rand_req("R3 R8 chain0", 64'h1111_2222_3333_4444, 16'h0000, 16'h0000, 1'b1);
        rand_req("R8 R5 chain1", 64'hAAAA_5555_AAAA_5555, 16'h00F0, 16'h0F00, 1'b1);
        rand_req("R8 chain2",    64'h0000_0000_0000_0001, 16'h8001, 16'h0000, 1'b0);
        rand_req("R5 chain3",    64'hFFFF_FFFF_FFFF_FFFF, 16'h0000, 16'h7FFE, 1'b0);
        rand_req("R9 chain4",    64'h0F00_0000_DEAD_BEEF, 16'h5555, 16'h0000, 1'b1);
        rand_req("R6 fullmask",  64'h0700_0000_0000_0000, 16'hFF00, 16'h00FF, 1'b1);
        check("R6 tag zero", {60'b0, state_out[3:0]}, 64'd0);
    endtask

    task automatic t_adjust;
        logic [23:0] keep;
        keep = state_out;
        run_req(1'b1, 64'h0500_0000_0000_0100, 16'hFFFF, 16'h0000, 1'b0, 16'hFFF0, 4'd1);
        check("R10 minus16 tag6", ptr_out, 64'h0600_0000_0000_00F0);
        check("R10 state kept", {40'b0, state_out}, {40'b0, keep});
        run_req(1'b1, 64'h0500_0000_0000_0000, 16'h0000, 16'hFFDF, 1'b0, 16'h0000, 4'd1);
        check("R8 full circle", ptr_out, 64'h0500_0000_0000_0000);
        run_req(1'b1, 64'h0500_0000_0000_0000, 16'h0000, 16'h0060, 1'b0, 16'h0002, 4'd0);
        check("R7 start excluded", ptr_out, 64'h0700_0000_0000_0002);
        run_req(1'b1, 64'h0F00_0000_0000_0000, 16'h0000, 16'h0000, 1'b0, 16'h7FFF, 4'd2);
        check("R10 R8 wrap", ptr_out, 64'h0100_0000_0000_7FFF);
        run_req(1'b1, 64'h0900_0000_0000_0000, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, 4'd3);
        check("R6 adjust fullmask", ptr_out, 64'h0000_0000_0000_0000);
        check("R10 state kept2", {40'b0, state_out}, {40'b0, keep});
    endtask

    task automatic t_busy_ignored;
        int w;
        int pulses;
        @(negedge clk);
        req_adj = 1'b1; ptr_in = 64'h0500_0000_0000_0000; excl_op = 16'h0;
        excl_glb = 16'hFFDF; byte_ofs = 16'h0; tag_ofs = 4'd1; req_valid = 1'b1;
        @(negedge clk);
        check("R2 busy after take", {63'b0, busy}, 64'd1);
        req_adj = 1'b0; ptr_in = 64'h0; excl_glb = 16'h0;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        w = 0; pulses = 0;
        while (w < 40) begin
            if (done) pulses++;
            if (done) check("R2 first request wins", ptr_out, 64'h0500_0000_0000_0000);
            @(negedge clk);
            w++;
        end
        check("R2 one pulse", pulses, 64'd1);
        check("R2 state untouched", {40'b0, state_out}, {40'b0, m_state});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_seed();
        t_mode_seed();
        t_chain();
        t_adjust();
        t_busy_ignored();
        report();
    end
endmodule